// File: doc/BRIEF.md
# Delta-Sample Fetch Engine with CPU Bus Stall

This block feeds the one-byte sample buffer of a 1-bit delta audio channel. It fetches bytes from CPU memory. The CPU has no bus-release handshake, so the engine takes the bus by pulling the CPU ready line low. It keeps the line low for a fixed number of cycles and performs its single read only in the last of them. The earlier cycles let any CPU write burst that is already running, such as an interrupt entry pushing its return address, finish first.

Software sets up a sample with three 8-bit register writes and a start command:
- The address register picks a 64-byte-aligned start in the top quarter of memory.
- The length register picks a byte count in steps of 16, plus one.
- The flags register holds the loop and IRQ-enable bits.

During playback the engine keeps a current address and a remaining-byte count. It fetches whenever the buffer reports empty and bytes remain. At the end of a sample it either restarts (loop) or raises a level interrupt that holds until software clears it.

Top module: `sample_fetch_unit`

## Requirements
- R1: The first byte of a sample is read from address 0xC000 + 64 × (address register value).
- R2: A sample is exactly 16 × (length register value) + 1 bytes long. After the last byte, no further read occurs while looping is off.
- R3: A start command loads the current address and the remaining count from the registers only when the remaining count is zero. While the count is nonzero, a start changes neither the address sequence nor the count.
- R4: A stall begins on the cycle after one in which `buf_empty` is high, the remaining count is nonzero and no stall is in progress. While `buf_empty` is low, no stall begins.
- R5: Each stall holds `cpu_rdy` low for exactly 4 consecutive cycles. `bus_req` and `buf_load` are high only in the fourth of these cycles, with `buf_data` equal to `bus_rdata`. `cpu_rdy` is high on the following cycle.
- R6: After each read the address advances by one. A read at 0xFFFF is followed by a read at 0x8000.
- R7: When the last byte is read while the loop flag (bit 0 of a flags write) is set, the sample restarts from the R1/R2 values. No interrupt is raised.
- R8: When the last byte is read with the loop flag clear and IRQ enable (bit 1 of a flags write) set, `irq` rises on the next cycle. It stays high until it is cleared per R9. With IRQ enable clear, `irq` stays low.
- R9: A flags write with bit 1 clear drops `irq` on the next cycle. A flags write with bit 1 set leaves `irq` unchanged.
- R10: A stop command zeroes the remaining count, so no new stall begins afterwards, even with `buf_empty` high.
- R11: After reset, `cpu_rdy` is high and `bus_req`, `buf_load` and `irq` are low. No stall begins until a start command is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_addr | input | 1 | Write strobe for the start-address register |
| cfg_wr_len | input | 1 | Write strobe for the length register |
| cfg_wr_flags | input | 1 | Write strobe for the flags (bit 0 loop, bit 1 IRQ enable) |
| cfg_wdata | input | 8 | Register write data |
| ctl_start | input | 1 | Start pulse (ignored while bytes remain) |
| ctl_stop | input | 1 | Stop pulse (zeroes the remaining count) |
| buf_empty | input | 1 | Sample buffer has no byte |
| buf_load | output | 1 | Loads `buf_data` into the sample buffer |
| buf_data | output | 8 | Fetched byte |
| bus_req | output | 1 | Read cycle owned by the engine |
| bus_addr | output | 16 | Read address, valid with `bus_req` |
| bus_rdata | input | 8 | Read data from memory |
| cpu_rdy | output | 1 | CPU ready, low while stalling |
| irq | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle:
- the shape of the stall: ready low for the full window, the read only in its last cycle, ready back high afterwards;
- that every read address lies in the upper half of memory;
- that a stall never starts without an empty buffer;
- that the interrupt holds until a clearing flags write, and drops after one.

Other behaviour can only be shown by the bench's scenarios, because it depends on configuration history:
- the exact start address and byte count derived from the registers;
- the wrap from 0xFFFF to 0x8000;
- looping without an interrupt;
- a start ignored in mid-sample;
- stop halting all later fetches.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int FLAG_LOOP_BIT = 0;
  localparam int FLAG_IRQ_BIT  = 1;

  typedef struct packed {
    logic irq_en;
    logic loop;
  } sfu_flags_t;
endpackage

// File: rtl/sfu_cfg_regs.sv
// Holds the three configuration registers and expands them into the
// start address and the byte count of a sample.
module sfu_cfg_regs
  import sfu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int ALIGN_SH = 6,
  parameter int LEN_SH   = 4,
  localparam int LW      = DW + LEN_SH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_len,
  input  logic          wr_flags,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] start_addr,
  output logic [LW-1:0] start_len,
  output sfu_flags_t    flags,
  output logic          irq_clear
);
  localparam logic [AW-1:0] BASE_ADDR = {2'b11, {(AW-2){1'b0}}};

  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] len_q,  len_d;
  sfu_flags_t    flg_q,  flg_d;
  logic          reg_ce;

  assign reg_ce = wr_addr | wr_len | wr_flags;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    flg_d  = flg_q;
    if (wr_addr) addr_d = wr_data;
    if (wr_len)  len_d  = wr_data;
    if (wr_flags) begin
      flg_d.loop   = wr_data[FLAG_LOOP_BIT];
      flg_d.irq_en = wr_data[FLAG_IRQ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      flg_q  <= '0;
    end else if (reg_ce) begin
      addr_q <= addr_d;
      len_q  <= len_d;
      flg_q  <= flg_d;
    end
  end

  assign start_addr = BASE_ADDR | (AW'(addr_q) << ALIGN_SH);
  assign start_len  = (LW'(len_q) << LEN_SH) | LW'(1);
  assign flags      = flg_q;
  assign irq_clear  = wr_flags & ~wr_data[FLAG_IRQ_BIT];
endmodule

// File: rtl/sfu_stall_seq.sv
// Fixed-length stall window: ready low for STALL_LEN cycles, the
// memory read slot being the last of them.
module sfu_stall_seq #(
  parameter int  STALL_LEN = 4,
  localparam int CW        = (STALL_LEN > 1) ? $clog2(STALL_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  output logic stalled,
  output logic read_slot
);
  localparam logic [CW-1:0] LAST = CW'(STALL_LEN - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          seq_ce;

  assign seq_ce = want | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (want) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (cnt_q == LAST) begin
      busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (seq_ce) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign stalled   = busy_q;
  assign read_slot = busy_q & (cnt_q == LAST);
endmodule

// File: rtl/sfu_read_ctr.sv
// Current address, remaining byte count and the end-of-sample flag.
module sfu_read_ctr #(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_cmd,
  input  logic          stop_cmd,
  input  logic          fetch_done,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          loop,
  input  logic          irq_en,
  input  logic          irq_clear,
  output logic [AW-1:0] cur_addr,
  output logic          rem_nz,
  output logic          irq
);
  localparam logic [AW-1:0] TOP_ADDR  = '1;
  localparam logic [AW-1:0] WRAP_ADDR = {1'b1, {(AW-1){1'b0}}};
  localparam logic [LW-1:0] ONE_LEFT  = LW'(1);

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q,  rem_d;
  logic          irq_q,  irq_d;
  logic          ctr_ce;

  assign ctr_ce = start_cmd | stop_cmd | fetch_done | irq_clear;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    irq_d  = irq_q;
    if (start_cmd && rem_q == '0) begin
      addr_d = start_addr;
      rem_d  = start_len;
    end
    if (fetch_done && rem_q != '0) begin
      addr_d = (addr_q == TOP_ADDR) ? WRAP_ADDR : addr_q + 1'b1;
      if (rem_q == ONE_LEFT) begin
        if (loop) begin
          addr_d = start_addr;
          rem_d  = start_len;
        end else begin
          rem_d = '0;
          if (irq_en) irq_d = 1'b1;
        end
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end
    if (stop_cmd)  rem_d = '0;
    if (irq_clear) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      irq_q  <= 1'b0;
    end else if (ctr_ce) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
      irq_q  <= irq_d;
    end
  end

  assign cur_addr = addr_q;
  assign rem_nz   = (rem_q != '0);
  assign irq      = irq_q;
endmodule

// File: rtl/sample_fetch_unit.sv
module sample_fetch_unit
  import sfu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ALIGN_SH  = 6,
  parameter int LEN_SH    = 4,
  parameter int STALL_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_addr,
  input  logic          cfg_wr_len,
  input  logic          cfg_wr_flags,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          ctl_start,
  input  logic          ctl_stop,
  input  logic          buf_empty,
  output logic          buf_load,
  output logic [DW-1:0] buf_data,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          cpu_rdy,
  output logic          irq
);
  localparam int LW = DW + LEN_SH;

  logic [AW-1:0] start_addr;
  logic [LW-1:0] start_len;
  sfu_flags_t    flags;
  logic          irq_clear;
  logic          stalled;
  logic          read_slot;
  logic          rem_nz;
  logic [AW-1:0] cur_addr;

  sfu_cfg_regs #(
    .AW(AW), .DW(DW), .ALIGN_SH(ALIGN_SH), .LEN_SH(LEN_SH)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(cfg_wr_addr), .wr_len(cfg_wr_len), .wr_flags(cfg_wr_flags),
    .wr_data(cfg_wdata),
    .start_addr(start_addr), .start_len(start_len),
    .flags(flags), .irq_clear(irq_clear)
  );

  sfu_stall_seq #(.STALL_LEN(STALL_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .want(buf_empty & rem_nz),
    .stalled(stalled), .read_slot(read_slot)
  );

  sfu_read_ctr #(.AW(AW), .LW(LW)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .start_cmd(ctl_start), .stop_cmd(ctl_stop), .fetch_done(read_slot),
    .start_addr(start_addr), .start_len(start_len),
    .loop(flags.loop), .irq_en(flags.irq_en), .irq_clear(irq_clear),
    .cur_addr(cur_addr), .rem_nz(rem_nz), .irq(irq)
  );

  assign cpu_rdy  = ~stalled;
  assign bus_req  = read_slot;
  assign bus_addr = read_slot ? cur_addr : '0;
  assign buf_load = read_slot;
  assign buf_data = bus_rdata;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
  import sfu_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int STALL_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr_flags,
  input logic [DW-1:0] cfg_wdata,
  input logic          buf_empty,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic          cpu_rdy,
  input logic          irq
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run <= '0;
    else if (cpu_rdy || bus_req) low_run <= '0;
    else                        low_run <= low_run + 1'b1;
  end

  // R5: the read happens only inside a stall
  a_r5_req_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_rdy);
  // R5: the read is in the last cycle of the window
  a_r5_read_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (low_run == 8'(STALL_LEN - 1)));
  // R5: ready is released right after the read
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> cpu_rdy);
  // R5: no stall ends before its read
  a_r5_no_short_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rdy && !bus_req) |=> !cpu_rdy);
  // R6: reads stay in the upper half of memory
  a_r6_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr[AW-1]);
  // R4: a stall starts only after an empty buffer was seen
  a_r4_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rdy) |-> $past(buf_empty));
  // R8: the interrupt holds until a clearing flags write
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_wr_flags && !cfg_wdata[FLAG_IRQ_BIT])) |=> irq);
  // R9: a flags write with IRQ enable clear drops the interrupt
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_flags && !cfg_wdata[FLAG_IRQ_BIT]) |=> !irq);
endmodule

bind sample_fetch_unit sfu_checker #(.AW(AW), .DW(DW), .STALL_LEN(STALL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_flags(cfg_wr_flags), .cfg_wdata(cfg_wdata),
  .buf_empty(buf_empty), .bus_req(bus_req), .bus_addr(bus_addr),
  .cpu_rdy(cpu_rdy), .irq(irq)
);

// File: tb/test_sample_fetch_unit.sv
module test_sample_fetch_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  l;
    logic        ie;
    logic [15:0] st;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'h00, 8'h00, 1'b1, 16'hC000, 8'd1},
    '{8'h05, 8'h01, 1'b1, 16'hC140, 8'd17},
    '{8'hFF, 8'h04, 1'b1, 16'hFFC0, 8'd65},
    '{8'h80, 8'h00, 1'b0, 16'hE000, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_addr, cfg_wr_len, cfg_wr_flags;
  logic [7:0]  cfg_wdata;
  logic        ctl_start, ctl_stop, buf_empty;
  logic        buf_load;
  logic [7:0]  buf_data;
  logic        bus_req;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata;
  logic        cpu_rdy, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_fetch_unit i_sample_fetch_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wr_len(cfg_wr_len), .cfg_wr_flags(cfg_wr_flags),
    .cfg_wdata(cfg_wdata), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
    .buf_empty(buf_empty), .buf_load(buf_load), .buf_data(buf_data),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .cpu_rdy(cpu_rdy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind 0 address, 1 length, 2 flags
  task automatic wr(input int kind, input logic [7:0] d);
    cfg_wdata    = d;
    cfg_wr_addr  = (kind == 0);
    cfg_wr_len   = (kind == 1);
    cfg_wr_flags = (kind == 2);
    @(negedge clk);
    cfg_wr_addr = 1'b0; cfg_wr_len = 1'b0; cfg_wr_flags = 1'b0;
    #1;
  endtask

  task automatic pulse(input bit stop);
    if (stop) ctl_stop = 1'b1; else ctl_start = 1'b1;
    @(negedge clk);
    ctl_stop = 1'b0; ctl_start = 1'b0;
    #1;
  endtask

  // Waits for the next read, returns its address and the low cycles before it
  task automatic wait_fetch(output logic [15:0] a, output bit got, output int low);
    got = 1'b0; a = '0; low = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bus_req) begin
        a = bus_addr;
        bus_rdata = a[7:0] ^ 8'h5A;
        #1;
        chk(buf_load && buf_data == (a[7:0] ^ 8'h5A) && !cpu_rdy,
            "R5 buffer load in read cycle", {23'd0, buf_load, buf_data}, {24'd1, a[7:0] ^ 8'h5A});
        got = 1'b1;
        return;
      end
      if (!cpu_rdy) low++;
      else          low = 0;
    end
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_req || !cpu_rdy) seen = 1'b1;
    end
    chk(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] a, expa;
    bit got;
    int low;

    rst_n = 1'b0;
    cfg_wr_addr = 1'b0; cfg_wr_len = 1'b0; cfg_wr_flags = 1'b0; cfg_wdata = '0;
    ctl_start = 1'b0; ctl_stop = 1'b0; buf_empty = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk(cpu_rdy && !bus_req && !buf_load && !irq, "R11 outputs in reset",
        {28'd0, cpu_rdy, bus_req, buf_load, irq}, 32'h8);
    rst_n = 1'b1;
    quiet(10, "R11 no stall without start");

    // Table of configurations
    foreach (VEC[v]) begin
      wr(2, 8'h00);
      wr(0, VEC[v].a);
      wr(1, VEC[v].l);
      wr(2, {6'd0, VEC[v].ie, 1'b0});
      buf_empty = 1'b1;
      pulse(1'b0);
      expa = VEC[v].st;
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        wait_fetch(a, got, low);
        if (k == 0) begin
          chk(got && a == expa, "R1 start address", {16'd0, a}, {16'd0, expa});
          chk(low == 3, "R5 three idle stall cycles before read", low, 3);
        end else begin
          chk(got && a == expa, "R6 address sequence", {16'd0, a}, {16'd0, expa});
        end
        expa = (expa == 16'hFFFF) ? 16'h8000 : expa + 16'd1;
      end
      @(negedge clk);
      chk(cpu_rdy, "R5 ready released after read", {31'd0, cpu_rdy}, 32'd1);
      chk(irq == VEC[v].ie, "R8 interrupt at sample end", {31'd0, irq}, {31'd0, VEC[v].ie});
      quiet(15, "R2 no read after last byte");
      buf_empty = 1'b0;
    end

    // R4 full buffer blocks fetching
    wr(2, 8'h00);
    wr(0, 8'h01);
    wr(1, 8'h01);
    buf_empty = 1'b0;
    pulse(1'b0);
    quiet(20, "R4 no stall while buffer full");
    buf_empty = 1'b1;
    @(negedge clk);
    chk(!cpu_rdy, "R4 stall begins the cycle after empty", {31'd0, cpu_rdy}, 32'd0);
    wait_fetch(a, got, low);
    chk(got && a == 16'hC040, "R4 first fetch address", {16'd0, a}, 32'hC040);
    wait_fetch(a, got, low);
    chk(got && a == 16'hC041, "R6 second fetch address", {16'd0, a}, 32'hC041);

    // R3 start ignored mid-sample
    wr(0, 8'h10);
    pulse(1'b0);
    wait_fetch(a, got, low);
    chk(got && a == 16'hC042, "R3 start ignored while bytes remain", {16'd0, a}, 32'hC042);

    // R10 stop
    buf_empty = 1'b0;
    pulse(1'b1);
    buf_empty = 1'b1;
    quiet(20, "R10 no stall after stop");

    // R7 looping
    wr(2, 8'h03);
    wr(0, 8'h02);
    wr(1, 8'h00);
    pulse(1'b0);
    for (int k = 0; k < 3; k++) begin
      wait_fetch(a, got, low);
      chk(got && a == 16'hC080, "R7 loop restarts at start address", {16'd0, a}, 32'hC080);
      @(negedge clk);
      chk(!irq, "R7 no interrupt while looping", {31'd0, irq}, 32'd0);
    end
    wr(2, 8'h02);
    wait_fetch(a, got, low);
    chk(got && a == 16'hC080, "R7 last byte after loop cleared", {16'd0, a}, 32'hC080);
    @(negedge clk);
    chk(irq, "R8 interrupt after loop cleared", {31'd0, irq}, 32'd1);
    quiet(10, "R2 single-byte sample ends");
    chk(irq, "R8 interrupt held", {31'd0, irq}, 32'd1);
    wr(2, 8'h02);
    chk(irq, "R9 enable-set write keeps interrupt", {31'd0, irq}, 32'd1);
    wr(2, 8'h00);
    chk(!irq, "R9 enable-clear write drops interrupt", {31'd0, irq}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule